// File: doc/BRIEF.md
# Circular Phase Window Selector

This block picks a receive sampling phase after a tuning sweep across a sixteen-tap delay line. A sweep reports which taps captured good data as a 16-bit pass mask, together with the number of passing taps. On a start strobe the block walks the mask one tap per clock. It groups adjacent passing taps into windows and keeps the longest window. It then returns the tap that lies three quarters of the way into that window, which leaves more margin on one side of the eye than a centre pick would.

The tap ring wraps around. A window that ends at tap 15 and a window that begins at tap 0 are therefore one window, and the block joins them. The chosen phase is counted from the window start modulo 16, so a joined window can yield a phase on either side of the wrap. Bad sweep summaries raise an error flag instead of a phase: a zero pass count, a count above 16, or an empty mask. A one-cycle done strobe marks each result, and the outputs hold until the next result is reported.

Top module: `phase_window_select`

## Requirements
- R1: After reset, done_o is 0, err_o is 0 and phase_o is 0.
- R2: Passing taps (mask bit p = 1 means tap p passed) that are adjacent in ascending order form one window, and any failing tap ends the window. The reported phase is (window start + offset) mod 16 for the longest window.
- R3: For a window of length L, the offset is floor(3*L/4), reduced by one when that value is nonzero. So lengths 1 and 2 give offset 0, 4 gives 2, 5 gives 2, 6 gives 3 and 8 gives 5.
- R4: When taps 0 and 15 both pass but not all taps pass, the window holding tap 15 and the window holding tap 0 count as one window. It starts at the start of the tap-15 window, and its length is the sum of both lengths.
- R5: Only a strictly longer window replaces the current best. Windows are ranked in the order in which they end while scanning upward, and a joined wrap window ranks last, so on a tie the earlier window wins.
- R6: With all 16 taps passing, the result is one window of 16 starting at tap 0, and phase_o is 11.
- R7: A pass count of 0, a pass count above 16, or an all-zero mask gives err_o = 1 with phase_o = 0.
- R8: done_o is high for exactly one cycle per result. phase_o and err_o keep their values until the next done_o.
- R9: Take the rising edge that samples start_i as edge 0. done_o is high after edge 17 for a valid sweep and after edge 1 for an error.
- R10: A start_i pulse that arrives while a selection is in progress is ignored, and the result reflects the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a selection; sampled only when idle |
| pass_mask_i | input | 16 | Per-tap pass result of the sweep |
| pass_count_i | input | 5 | Number of passing taps reported by the sweep |
| done_o | output | 1 | One-cycle result strobe |
| phase_o | output | 4 | Selected sampling tap |
| err_o | output | 1 | Result is invalid |

## Verification
The main function is driven with several mask shapes. A lone tap and a single interior run test the basic offset rule. Two joined wrap masks test the merge: one lands before the wrap and one lands past it, which shows whether the result is reduced modulo 16. Two equal-length runs, and an equal-length pair in which one window is a joined wrap window, test the tie ranking. A short early run followed by a longer later run shows that a longer window replaces the current best. The full mask and the three malformed inputs cover the remaining boundaries, and a second start issued mid-scan shows that a request is not restarted.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_REPORT = 2'd2
  } pws_state_e;

  // Three-quarter position inside a window of len taps, zero-based.
  function automatic int unsigned window_offset(input int unsigned len);
    int unsigned q;
    q = (len * 3) / 4;
    return (q != 0) ? q - 1 : 0;
  endfunction

endpackage

// File: rtl/pws_run_scan.sv
module pws_run_scan
  import pws_pkg::*;
#(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [NPH-1:0] mask_i,
  input  logic [PW-1:0] idx_i,
  output logic          cand_valid_o,
  output logic [LW-1:0] cand_len_o,
  output logic [PW-1:0] cand_start_o,
  output logic          defer_o
);

  logic [LW-1:0] run_len_q, head_len_q;
  logic [PW-1:0] run_start_q;
  logic [NPH:0]  mask_ext_w;
  logic          bit_w, next_w, last_w, wrap_w, ends_w;
  logic [LW-1:0] cur_len_w;
  logic [PW-1:0] cur_start_w;

  always_comb begin
    mask_ext_w  = {1'b0, mask_i};
    bit_w       = mask_i[idx_i];
    next_w      = mask_ext_w[LW'(idx_i) + LW'(1)];
    last_w      = (idx_i == PW'(NPH - 1));
    wrap_w      = mask_i[0] & mask_i[NPH-1] & ~(&mask_i);
    cur_len_w   = (run_len_q == '0) ? LW'(1) : run_len_q + LW'(1);
    cur_start_w = (run_len_q == '0) ? idx_i : run_start_q;
    ends_w      = step_i & bit_w & ~next_w;
    defer_o     = ends_w & wrap_w & (cur_start_w == '0);
    cand_valid_o = ends_w & ~defer_o;
    cand_len_o   = (last_w & wrap_w) ? cur_len_w + head_len_q : cur_len_w;
    cand_start_o = cur_start_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q   <= '0;
      run_start_q <= '0;
      head_len_q  <= '0;
    end else if (clear_i) begin
      run_len_q   <= '0;
      run_start_q <= '0;
      head_len_q  <= '0;
    end else if (step_i) begin
      if (bit_w) begin
        run_len_q   <= ends_w ? '0 : cur_len_w;
        run_start_q <= cur_start_w;
      end else begin
        run_len_q <= '0;
      end
      if (defer_o) head_len_q <= cur_len_w;
    end
  end

endmodule

// File: rtl/pws_best_keep.sv
module pws_best_keep #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          cand_valid_i,
  input  logic [LW-1:0] cand_len_i,
  input  logic [PW-1:0] cand_start_i,
  output logic          upd_o,
  output logic [LW-1:0] best_len_o,
  output logic [PW-1:0] best_start_o
);

  assign upd_o = cand_valid_i & (cand_len_i > best_len_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_len_o   <= '0;
      best_start_o <= '0;
    end else if (clear_i) begin
      best_len_o   <= '0;
      best_start_o <= '0;
    end else if (upd_o) begin
      best_len_o   <= cand_len_i;
      best_start_o <= cand_start_i;
    end
  end

endmodule

// File: rtl/phase_window_select.sv
module phase_window_select
  import pws_pkg::*;
#(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1,
  localparam int CW = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NPH-1:0] pass_mask_i,
  input  logic [CW-1:0]  pass_count_i,
  output logic           done_o,
  output logic [PW-1:0]  phase_o,
  output logic           err_o
);

  pws_state_e     state_q;
  logic [PW-1:0]  idx_q;
  logic [NPH-1:0] mask_q;
  logic           bad_q;

  logic           idle_w, accept_w, bad_in_w, step_w;
  logic           cand_valid_w, defer_w, upd_w;
  logic [LW-1:0]  cand_len_w, best_len_w;
  logic [PW-1:0]  cand_start_w, best_start_w, pick_w;
  int unsigned    sum_w;

  always_comb begin
    idle_w   = (state_q == ST_IDLE);
    accept_w = idle_w & start_i;
    step_w   = (state_q == ST_SCAN);
    bad_in_w = (pass_count_i == '0) || (32'(pass_count_i) > NPH) ||
               (pass_mask_i == '0);
    sum_w    = 32'(best_start_w) + window_offset(32'(best_len_w));
    pick_w   = PW'(sum_w % NPH);
  end

  pws_run_scan #(.NPH(NPH)) scan_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (accept_w),
    .step_i       (step_w),
    .mask_i       (mask_q),
    .idx_i        (idx_q),
    .cand_valid_o (cand_valid_w),
    .cand_len_o   (cand_len_w),
    .cand_start_o (cand_start_w),
    .defer_o      (defer_w)
  );

  pws_best_keep #(.NPH(NPH)) best_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (accept_w),
    .cand_valid_i (cand_valid_w),
    .cand_len_i   (cand_len_w),
    .cand_start_i (cand_start_w),
    .upd_o        (upd_w),
    .best_len_o   (best_len_w),
    .best_start_o (best_start_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      bad_q   <= 1'b0;
      done_o  <= 1'b0;
      phase_o <= '0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q  <= pass_mask_i;
            idx_q   <= '0;
            bad_q   <= bad_in_w;
            state_q <= bad_in_w ? ST_REPORT : ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + PW'(1);
          if (idx_q == PW'(NPH - 1)) state_q <= ST_REPORT;
        end
        ST_REPORT: begin
          done_o  <= 1'b1;
          err_o   <= bad_q;
          phase_o <= bad_q ? '0 : pick_w;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pws_sel_chk.sv
module pws_sel_chk #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = PW + 1,
  localparam int CW = PW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] pass_count_i,
  input logic          done_o,
  input logic [PW-1:0] phase_o,
  input logic          err_o,
  input logic          idle_w,
  input logic          upd_w,
  input logic [LW-1:0] best_len_w
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || ($stable(phase_o) && $stable(err_o))));

  // R7
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && start_i && (pass_count_i == '0 || 32'(pass_count_i) > NPH))
      |=> ##1 (done_o && err_o));

  // R7
  err_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (phase_o == '0));

  // R5
  best_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_w |=> (best_len_w > $past(best_len_w)));

endmodule

bind phase_window_select pws_sel_chk #(.NPH(NPH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .pass_count_i (pass_count_i),
  .done_o       (done_o),
  .phase_o      (phase_o),
  .err_o        (err_o),
  .idle_w       (idle_w),
  .upd_w        (upd_w),
  .best_len_w   (best_len_w)
);

// File: tb/phase_window_select_tb.sv
`timescale 1ns/1ps
module phase_window_select_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pass_mask_i = '0;
  logic [4:0]  pass_count_i = '0;
  logic        done_o;
  logic [3:0]  phase_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phase_window_select dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pass_mask_i(pass_mask_i), .pass_count_i(pass_count_i),
    .done_o(done_o), .phase_o(phase_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: list runs, fold the first into the last on wrap.
  function automatic int model_phase(input logic [15:0] m);
    int st[16];
    int ln[16];
    int n = 0;
    int best = 0;
    int bl = 0;
    int off;
    for (int p = 0; p < 16; p++) begin
      if (m[p]) begin
        if (p == 0 || !m[p-1]) begin
          st[n] = p; ln[n] = 0; n++;
        end
        ln[n-1]++;
      end
    end
    if (m[0] && m[15] && n > 1) begin
      ln[n-1] += ln[0];
      ln[0] = 0;
    end
    for (int k = 0; k < n; k++)
      if (ln[k] > bl) begin bl = ln[k]; best = k; end
    off = (bl * 3) / 4;
    if (off > 0) off--;
    return (st[best] + off) % 16;
  endfunction

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int p = 0; p < 16; p++) c += m[p];
    return c;
  endfunction

  // Issue a request, wait for done, check result, latency and hold.
  task automatic run_case(input string req, input logic [15:0] m,
                          input int cnt, input bit exp_err, input int exp_ph);
    int n = 0;
    @(negedge clk);
    pass_mask_i = m; pass_count_i = 5'(cnt); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (!done_o) begin
      while (n < 100) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (done_o) break;
      end
    end
    check({req, " done"}, done_o, 1);
    check({req, " err"}, err_o, exp_err);
    check({req, " phase"}, phase_o, exp_ph);
    check({req, " R9 latency"}, n, exp_err ? 1 : 17);
    @(negedge clk);
    check({req, " R8 single-cycle done"}, done_o, 0);
    repeat (3) @(negedge clk);
    check({req, " R8 phase held"}, phase_o, exp_ph);
    check({req, " R8 err held"}, err_o, exp_err);
  endtask

  task automatic valid_case(input string req, input logic [15:0] m, input int exp_ph);
    check({req, " model agrees"}, model_phase(m), exp_ph);
    run_case(req, m, popc(m), 1'b0, exp_ph);
  endtask

  task automatic t_reset;
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);
    check("R1 phase", phase_o, 0);
  endtask

  task automatic t_basic;
    valid_case("R2 single tap 5", 16'h0020, 5);
    valid_case("R3 run 4..11 len8", 16'h0FF0, 9);
    valid_case("R3 run 2..3 len2", 16'h000C, 2);
  endtask

  task automatic t_wrap;
    // taps 13,14,15,0,1 plus 6..8 ; joined start 13 len5 -> 15
    valid_case("R4 wrap before edge", 16'hE1C3, 15);
    // taps 14,15,0..3 ; joined len6 -> (14+3)%16 = 1
    valid_case("R4 wrap past edge", 16'hC00F, 1);
  endtask

  task automatic t_ties;
    // runs 1..3 and 8..10 len3 each -> earlier, 1+1 = 2
    valid_case("R5 tie earliest", 16'h070E, 2);
    // runs 0..1 (+15 joined, len3) and 5..7 len3 -> 5..7 wins -> 6
    valid_case("R5 tie vs joined", 16'h80E3, 6);
    // runs 0..1 and 9..13 len5 -> 9+2 = 11
    valid_case("R5 longer later", 16'h3E03, 11);
  endtask

  task automatic t_full;
    valid_case("R6 all pass", 16'hFFFF, 11);
  endtask

  task automatic t_errors;
    run_case("R7 count zero", 16'h00F0, 0, 1'b1, 0);
    run_case("R7 count 17", 16'h00F0, 17, 1'b1, 0);
    run_case("R7 empty mask", 16'h0000, 3, 1'b1, 0);
  endtask

  task automatic t_busy_start;
    int n = 0;
    @(negedge clk);
    pass_mask_i = 16'h0F00; pass_count_i = 5'd4; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    pass_mask_i = 16'h0003; pass_count_i = 5'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 100) begin @(negedge clk); n++; end
    check("R10 busy start done", done_o, 1);
    check("R10 busy start ignored", phase_o, 10);
    check("R10 busy start err", err_o, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_ties();
    t_full();
    t_errors();
    t_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule